// File: doc/BRIEF.md
# Equalizer Boost Adaptation Controller

This controller picks one setting for a continuous-time equalizer. The equalizer has four stages, and each stage takes a 2-bit boost code. The candidates come from a small table that software can rewrite. After reset, or after a restart, the controller walks the table indices in ascending order. It presents each entry on `eq_setting_o` for a programmable dwell time. It then samples an external figure-of-merit score `fom_i` and remembers the entry with the highest score. When the walk ends it raises `adapt_done_o`, drives the winning entry and shows the winning index on `cur_idx_o`.

Once the recovery loop reports lock, the chosen setting is frozen in a private register. Later table writes and later scores have no effect on it. Two pulses release the freeze and start a new search: an explicit re-adapt (`readapt_i`) and a report that the recovery loop has gone back to acquisition (`acq_enter_i`). The controller also reports the summed boost of the setting it drives. It passes a static flag through a register; this flag turns the last stage into a limiting stage.

The state machine has four states:
- `S_DWELL` presents the current index and counts the dwell.
- `S_SCORE` samples the score and either advances the index or ends the walk.
- `S_SETTLE` marks the search as done and waits for lock.
- `S_HOLD` keeps the frozen setting.

Its transitions are:
- dwell expiry: `S_DWELL` to `S_SCORE`.
- next index: `S_SCORE` to `S_DWELL`.
- last index: `S_SCORE` to `S_SETTLE`.
- lock seen: `S_SETTLE` to `S_HOLD`.
- restart: from any state to `S_DWELL` at index 0. A restart outranks every other transition.

Top module: `eq_adapt_ctrl`

## Requirements
- R1: During reset and right after it, `adapt_done_o` is low, `cur_idx_o` is 0, the search runs from index 0, and `stage4_limit_o` is 0.
- R2: Reset fills entry i with level L = floor(i*12/(N-1)), where N is the number of entries. Stage s sits in bits [2s+1:2s] and holds the code min(3, max(0, L-3s)), so the defaults rise in summed boost.
- R3: The search visits indices 0 to N-1 in ascending order. One cycle after the last score is sampled, `adapt_done_o` rises, `cur_idx_o` shows the index with the highest score, and `eq_setting_o` equals that entry.
- R4: When scores tie, the lower index wins.
- R5: Each index is presented for max(dwell_i,1) cycles, plus one scoring cycle in which `fom_i` is sampled. The index therefore advances by one every max(dwell_i,1)+1 cycles.
- R6: `boost_level_o` is the sum of the four 2-bit stage codes of `eq_setting_o`, from 0 to 12.
- R7: A write with `wr_en_i` high replaces entry `wr_addr_i` with `wr_data_i` from the next cycle on. Any of the 256 values is accepted.
- R8: Once `adapt_done_o` and `lock_i` are high together, `eq_setting_o`, `cur_idx_o` and `adapt_done_o` stay fixed until a restart. Writes to the table and changes of `fom_i` have no effect on them.
- R9: A one-cycle pulse on `readapt_i` or `acq_enter_i` makes the next cycle show `adapt_done_o` low and `cur_idx_o` 0, and a new search begins.
- R10: `stage4_limit_o` equals `stage4_limit_i` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Recovery loop reports lock |
| readapt_i | input | 1 | Pulse: manual re-adapt request |
| acq_enter_i | input | 1 | Pulse: recovery loop has re-entered acquisition |
| dwell_i | input | DWELL_W | Dwell cycles per candidate (0 is treated as 1) |
| fom_i | input | FOM_W | Score of the candidate currently presented |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | IDX_W | Table write index |
| wr_data_i | input | STAGES*CODE_W | Table write value |
| stage4_limit_i | input | 1 | Limiting mode for the last stage |
| eq_setting_o | output | STAGES*CODE_W | Stage codes driven to the equalizer |
| boost_level_o | output | LVL_W | Summed boost of `eq_setting_o` |
| cur_idx_o | output | IDX_W | Index under test, or the winning index once done |
| adapt_done_o | output | 1 | Search complete |
| stage4_limit_o | output | 1 | Registered limiting-mode flag |

## Verification
The bench builds the block with IDX_W=3 (eight entries), FOM_W=6 and DWELL_W=4. Because the table is short, the bench can watch every index of the walk, cycle by cycle, against its own model of the table, and it can run several complete searches. In these runs it changes the dwell, including the zero-dwell case, uses a distinct peak, a two-way tie and an all-zero score set, and tries both restart sources. The eight-entry defaults cover levels 0, 1, 3, 5, 6, 8, 10 and 12, so the filling rule is exercised from empty to full boost.

// File: rtl/eq_adapt_pkg.sv
package eq_adapt_pkg;

    typedef enum logic [1:0] {
        S_DWELL  = 2'd0,
        S_SCORE  = 2'd1,
        S_SETTLE = 2'd2,
        S_HOLD   = 2'd3
    } adapt_state_e;

endpackage

// File: rtl/eq_table.sv
module eq_table #(
    parameter int IDX_W     = 5,
    parameter int N_ENTRIES = 32,
    parameter int STAGES    = 4,
    parameter int CODE_W    = 2,
    parameter int SET_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [SET_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SET_W-1:0] rd_data
);
    localparam int MAXC = (1 << CODE_W) - 1;

    logic [SET_W-1:0] mem [N_ENTRIES];

    // default entry: level rises with index, stage 0 saturates first
    function automatic logic [SET_W-1:0] dflt_entry(int idx);
        int lvl;
        int code;
        logic [SET_W-1:0] v;
        v   = '0;
        lvl = (N_ENTRIES > 1) ? (idx * STAGES * MAXC) / (N_ENTRIES - 1) : 0;
        for (int s = 0; s < STAGES; s++) begin
            code = lvl - MAXC * s;
            if (code < 0)    code = 0;
            if (code > MAXC) code = MAXC;
            v[s*CODE_W +: CODE_W] = CODE_W'(code);
        end
        return v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_ENTRIES; k++) mem[k] <= dflt_entry(k);
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/eq_boost_sum.sv
module eq_boost_sum #(
    parameter int STAGES = 4,
    parameter int CODE_W = 2,
    parameter int SET_W  = 8,
    parameter int LVL_W  = 4
) (
    input  logic [SET_W-1:0] setting,
    output logic [LVL_W-1:0] level
);
    always_comb begin
        level = '0;
        for (int s = 0; s < STAGES; s++)
            level = level + LVL_W'(setting[s*CODE_W +: CODE_W]);
    end
endmodule

// File: rtl/eq_search_fsm.sv
module eq_search_fsm
    import eq_adapt_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int FOM_W   = 8,
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               lock,
    input  logic [DWELL_W-1:0] dwell,
    input  logic [FOM_W-1:0]   fom,
    output logic [IDX_W-1:0]   sel_idx,
    output logic               done,
    output logic               capture,
    output logic               hold
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    adapt_state_e       state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   best_idx_q;
    logic [FOM_W-1:0]   best_fom_q;
    logic [DWELL_W-1:0] cnt_q;
    logic               dwell_end;
    logic               last_idx;

    assign dwell_end = (dwell == '0) || (cnt_q == dwell - 1'b1);
    assign last_idx  = (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_DWELL;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_DWELL:  if (dwell_end) state_d = S_SCORE;
            S_SCORE:  state_d = last_idx ? S_SETTLE : S_DWELL;
            S_SETTLE: if (lock) state_d = S_HOLD;
            S_HOLD:   state_d = S_HOLD;
        endcase
        if (restart) state_d = S_DWELL;
    end

    // search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            cnt_q      <= '0;
            best_idx_q <= '0;
            best_fom_q <= '0;
        end else if (restart) begin
            idx_q      <= '0;
            cnt_q      <= '0;
            best_idx_q <= '0;
            best_fom_q <= '0;
        end else begin
            unique case (state_q)
                S_DWELL: cnt_q <= dwell_end ? '0 : cnt_q + 1'b1;
                S_SCORE: begin
                    // strict compare: a tie keeps the earlier index
                    if (idx_q == '0 || fom > best_fom_q) begin
                        best_fom_q <= fom;
                        best_idx_q <= idx_q;
                    end
                    if (!last_idx) idx_q <= idx_q + 1'b1;
                end
                S_SETTLE, S_HOLD: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done    = 1'b0;
        hold    = 1'b0;
        capture = 1'b0;
        sel_idx = idx_q;
        unique case (state_q)
            S_DWELL, S_SCORE: ;
            S_SETTLE: begin
                done    = 1'b1;
                sel_idx = best_idx_q;
                capture = lock && !restart;
            end
            S_HOLD: begin
                done    = 1'b1;
                hold    = 1'b1;
                sel_idx = best_idx_q;
            end
        endcase
    end
endmodule

// File: rtl/eq_adapt_ctrl.sv
module eq_adapt_ctrl #(
    parameter int IDX_W   = 5,
    parameter int STAGES  = 4,
    parameter int CODE_W  = 2,
    parameter int FOM_W   = 8,
    parameter int DWELL_W = 8,
    parameter int SET_W   = STAGES * CODE_W,
    parameter int LVL_W   = $clog2(STAGES * ((1 << CODE_W) - 1) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_i,
    input  logic               readapt_i,
    input  logic               acq_enter_i,
    input  logic [DWELL_W-1:0] dwell_i,
    input  logic [FOM_W-1:0]   fom_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_addr_i,
    input  logic [SET_W-1:0]   wr_data_i,
    input  logic               stage4_limit_i,
    output logic [SET_W-1:0]   eq_setting_o,
    output logic [LVL_W-1:0]   boost_level_o,
    output logic [IDX_W-1:0]   cur_idx_o,
    output logic               adapt_done_o,
    output logic               stage4_limit_o
);
    localparam int N_ENTRIES = 1 << IDX_W;

    logic             restart;
    logic [IDX_W-1:0] sel_idx;
    logic [SET_W-1:0] tbl_data;
    logic [SET_W-1:0] held_q;
    logic             done;
    logic             capture;
    logic             hold;
    logic             limit_q;

    assign restart = readapt_i | acq_enter_i;

    eq_table #(
        .IDX_W(IDX_W), .N_ENTRIES(N_ENTRIES), .STAGES(STAGES),
        .CODE_W(CODE_W), .SET_W(SET_W)
    ) i_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .rd_idx(sel_idx), .rd_data(tbl_data)
    );

    eq_search_fsm #(
        .IDX_W(IDX_W), .FOM_W(FOM_W), .DWELL_W(DWELL_W)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .restart(restart), .lock(lock_i),
        .dwell(dwell_i), .fom(fom_i), .sel_idx(sel_idx), .done(done),
        .capture(capture), .hold(hold)
    );

    // frozen copy of the winning entry, taken on the step into hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       held_q <= '0;
        else if (capture) held_q <= tbl_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) limit_q <= 1'b0;
        else        limit_q <= stage4_limit_i;
    end

    assign eq_setting_o   = hold ? held_q : tbl_data;
    assign cur_idx_o      = sel_idx;
    assign adapt_done_o   = done;
    assign stage4_limit_o = limit_q;

    eq_boost_sum #(
        .STAGES(STAGES), .CODE_W(CODE_W), .SET_W(SET_W), .LVL_W(LVL_W)
    ) i_sum (
        .setting(eq_setting_o), .level(boost_level_o)
    );
endmodule

// File: rtl/eq_adapt_chk.sv
module eq_adapt_chk #(
    parameter int IDX_W  = 5,
    parameter int STAGES = 4,
    parameter int CODE_W = 2,
    parameter int SET_W  = 8,
    parameter int LVL_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock_i,
    input logic             readapt_i,
    input logic             acq_enter_i,
    input logic             stage4_limit_i,
    input logic [SET_W-1:0] eq_setting_o,
    input logic [LVL_W-1:0] boost_level_o,
    input logic [IDX_W-1:0] cur_idx_o,
    input logic             adapt_done_o,
    input logic             stage4_limit_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;
    localparam int MAX_LVL = STAGES * ((1 << CODE_W) - 1);

    // R6: summed boost never exceeds full boost
    p_boost_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(boost_level_o) <= MAX_LVL);

    // R3: completion follows scoring of the last index
    p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adapt_done_o) |-> $past(cur_idx_o) == LAST_IDX);

    // R5: during a search the index only holds or steps up by one
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adapt_done_o && !readapt_i && !acq_enter_i) |=>
        (adapt_done_o || cur_idx_o == $past(cur_idx_o) ||
         cur_idx_o == $past(cur_idx_o) + 1'b1));

    // R8: done with lock and no restart freezes the outputs
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adapt_done_o && lock_i && !readapt_i && !acq_enter_i) |=>
        ($stable(eq_setting_o) && $stable(cur_idx_o) && adapt_done_o));

    // R9: a restart pulse reopens the search at index 0
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (readapt_i || acq_enter_i) |=> (!adapt_done_o && cur_idx_o == '0));

    // R10: limiting flag is a one-cycle delay of its input
    p_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> stage4_limit_o == $past(stage4_limit_i));
endmodule

bind eq_adapt_ctrl eq_adapt_chk #(
    .IDX_W(IDX_W), .STAGES(STAGES), .CODE_W(CODE_W), .SET_W(SET_W), .LVL_W(LVL_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .readapt_i(readapt_i),
    .acq_enter_i(acq_enter_i), .stage4_limit_i(stage4_limit_i),
    .eq_setting_o(eq_setting_o), .boost_level_o(boost_level_o),
    .cur_idx_o(cur_idx_o), .adapt_done_o(adapt_done_o),
    .stage4_limit_o(stage4_limit_o)
);

// File: tb/test_eq_adapt_ctrl.sv
module test_eq_adapt_ctrl;
    localparam int IDX_W   = 3;
    localparam int N       = 1 << IDX_W;
    localparam int FOM_W   = 6;
    localparam int DWELL_W = 4;
    localparam int SET_W   = 8;
    localparam int LVL_W   = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               lock_i = 1'b0;
    logic               readapt_i = 1'b0;
    logic               acq_enter_i = 1'b0;
    logic [DWELL_W-1:0] dwell_i = 4'd3;
    logic [FOM_W-1:0]   fom_i;
    logic               wr_en_i = 1'b0;
    logic [IDX_W-1:0]   wr_addr_i = '0;
    logic [SET_W-1:0]   wr_data_i = '0;
    logic               stage4_limit_i = 1'b0;
    logic [SET_W-1:0]   eq_setting_o;
    logic [LVL_W-1:0]   boost_level_o;
    logic [IDX_W-1:0]   cur_idx_o;
    logic               adapt_done_o;
    logic               stage4_limit_o;

    always #10 clk = ~clk;

    eq_adapt_ctrl #(.IDX_W(IDX_W), .FOM_W(FOM_W), .DWELL_W(DWELL_W)) i_eq_adapt_ctrl (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .readapt_i(readapt_i),
        .acq_enter_i(acq_enter_i), .dwell_i(dwell_i), .fom_i(fom_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .stage4_limit_i(stage4_limit_i), .eq_setting_o(eq_setting_o),
        .boost_level_o(boost_level_o), .cur_idx_o(cur_idx_o),
        .adapt_done_o(adapt_done_o), .stage4_limit_o(stage4_limit_o)
    );

    logic [FOM_W-1:0] fom_tbl [N];
    logic [SET_W-1:0] exp_tbl [N];
    assign fom_i = fom_tbl[cur_idx_o];

    typedef struct { int idx; logic [SET_W-1:0] set; } exp_t;
    exp_t sbq[$];
    exp_t got;

    int  checks = 0;
    int  fails  = 0;
    bit  prev_done = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [SET_W-1:0] model_dflt(int i);
        int lvl;
        int c;
        logic [SET_W-1:0] v;
        v   = '0;
        lvl = (i * 12) / (N - 1);
        for (int s = 0; s < 4; s++) begin
            c = lvl - 3 * s;
            if (c < 0) c = 0;
            if (c > 3) c = 3;
            v[2*s +: 2] = 2'(c);
        end
        return v;
    endfunction

    function automatic int model_lvl(logic [SET_W-1:0] v);
        int t;
        t = 0;
        for (int s = 0; s < 4; s++) t += int'(v[2*s +: 2]);
        return t;
    endfunction

    // monitor: per-index setting during the walk, scoreboard pop at completion
    always @(negedge clk) begin
        if (rst_n) begin
            if (!adapt_done_o) begin
                chk(eq_setting_o == exp_tbl[cur_idx_o], "R2", "entry under test",
                    int'(eq_setting_o), int'(exp_tbl[cur_idx_o]));
                chk(int'(boost_level_o) == model_lvl(eq_setting_o), "R6", "boost sum",
                    int'(boost_level_o), model_lvl(eq_setting_o));
            end else if (!prev_done) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected completion", 1, 0);
                end else begin
                    got = sbq.pop_front();
                    chk(int'(cur_idx_o) == got.idx, "R3", "winning index",
                        int'(cur_idx_o), got.idx);
                    chk(eq_setting_o == got.set, "R4", "winning setting",
                        int'(eq_setting_o), int'(got.set));
                    chk(int'(boost_level_o) == model_lvl(got.set), "R6", "winner boost",
                        int'(boost_level_o), model_lvl(got.set));
                end
            end
            prev_done = adapt_done_o;
        end
    end

    function automatic int best_of();
        int b;
        b = 0;
        for (int i = 1; i < N; i++) if (fom_tbl[i] > fom_tbl[b]) b = i;
        return b;
    endfunction

    task automatic push_expected();
        exp_t e;
        e.idx = best_of();
        e.set = exp_tbl[e.idx];
        sbq.push_back(e);
    endtask

    task automatic measure_dwell(int d);
        int n;
        while (cur_idx_o != 3'd1) @(negedge clk);
        n = 0;
        while (cur_idx_o == 3'd1) begin
            @(negedge clk);
            n++;
        end
        chk(n == ((d == 0) ? 1 : d) + 1, "R5", "cycles per index", n, ((d == 0) ? 1 : d) + 1);
    endtask

    task automatic wait_empty();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic write_entry(int a, logic [SET_W-1:0] d);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_addr_i = IDX_W'(a);
        wr_data_i = d;
        @(posedge clk);
        exp_tbl[a] = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // driver: push expectation, pulse a restart source, follow the walk
    task automatic search(int d, bit via_acq);
        push_expected();
        @(negedge clk);
        dwell_i = DWELL_W'(d);
        if (via_acq) acq_enter_i = 1'b1; else readapt_i = 1'b1;
        @(negedge clk);
        acq_enter_i = 1'b0;
        readapt_i   = 1'b0;
        chk(!adapt_done_o, "R9", "done after restart", int'(adapt_done_o), 0);
        chk(cur_idx_o == '0, "R9", "index after restart", int'(cur_idx_o), 0);
        measure_dwell(d);
        wait_empty();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    logic [SET_W-1:0] frozen;

    initial begin
        for (int i = 0; i < N; i++) exp_tbl[i] = model_dflt(i);
        // run 1: distinct peak at index 5, started by reset
        for (int i = 0; i < N; i++) fom_tbl[i] = FOM_W'(i + 1);
        fom_tbl[5] = 6'd20;
        push_expected();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!adapt_done_o, "R1", "done at reset", int'(adapt_done_o), 0);
        chk(cur_idx_o == '0, "R1", "index at reset", int'(cur_idx_o), 0);
        chk(stage4_limit_o == 1'b0, "R1", "limit at reset", int'(stage4_limit_o), 0);
        measure_dwell(3);
        wait_empty();

        // freeze: lock, then table writes and score changes must not matter
        @(negedge clk);
        lock_i = 1'b1;
        repeat (2) @(negedge clk);
        frozen = eq_setting_o;
        chk(frozen == 8'h2F, "R2", "default entry 5", int'(frozen), 8'h2F);
        write_entry(5, 8'h00);
        for (int i = 0; i < N; i++) fom_tbl[i] = 6'd63;
        repeat (3) @(negedge clk);
        chk(eq_setting_o == frozen, "R8", "held setting", int'(eq_setting_o), int'(frozen));
        chk(cur_idx_o == 3'd5, "R8", "held index", int'(cur_idx_o), 5);
        chk(adapt_done_o, "R8", "held done", int'(adapt_done_o), 1);

        // run 2: tie between 2 and 6, restart from acquisition re-entry
        for (int i = 0; i < N; i++) fom_tbl[i] = 6'd9;
        fom_tbl[2] = 6'd30;
        fom_tbl[6] = 6'd30;
        search(1, 1'b1);

        // run 3: rewritten entry wins, zero dwell, manual re-adapt
        write_entry(7, 8'hE4);
        for (int i = 0; i < N; i++) fom_tbl[i] = 6'd10;
        fom_tbl[7] = 6'd63;
        search(0, 1'b0);
        chk(eq_setting_o == 8'hE4, "R7", "written entry applied", int'(eq_setting_o), 8'hE4);

        // run 4: all scores zero, lowest index wins
        for (int i = 0; i < N; i++) fom_tbl[i] = 6'd0;
        search(2, 1'b0);
        chk(cur_idx_o == '0, "R4", "all-zero tie", int'(cur_idx_o), 0);

        // limiting flag
        @(negedge clk);
        stage4_limit_i = 1'b1;
        @(negedge clk);
        chk(stage4_limit_o == 1'b1, "R10", "limit set", int'(stage4_limit_o), 1);
        stage4_limit_i = 1'b0;
        @(negedge clk);
        chk(stage4_limit_o == 1'b0, "R10", "limit clear", int'(stage4_limit_o), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule